// File: doc/BRIEF.md
# Symmetric-Coefficient FIR Lowpass Filter

This block is a streaming, single-channel lowpass filter with a finite impulse response and one hundred taps. Signed samples come in on a valid/ready stream and leave as signed, filtered samples on a stream that has a valid flag and no backpressure. Each accepted input produces exactly one output after a fixed number of clock edges. The filter can take one sample per clock.

The coefficient set is even-symmetric, so the block stores only the first half of it. On every output it first adds each sample to its mirror-image partner in the delay line. This halves the number of multipliers. The products are summed at full precision. The sum is then scaled down by the coefficient fraction width, rounded, and clipped to the output range.

The default coefficients form a Blackman-windowed lowpass for a 32 MHz sample rate with a cutoff near 1.5 MHz. A 500 kHz tone passes through, and a 5 MHz tone is strongly suppressed. An integrator can override the coefficient set, the fraction width and the widths through parameters.

Top module: `fir_sym_lowpass`

## Requirements
- R1: With a coefficient list c[0..99], an impulse of amplitude 2^FRAC_W followed by zeros produces 100 outputs equal to c[0], c[1], ..., c[99] in that order. In general, output n is the rounded, scaled value of the sum over k of c[k]·x[n−k].
- R2: Only taps 0..49 are stored. Coefficient k occupies bits [k·COEF_W +: COEF_W] of `COEFS` as a signed value, and tap 99−k uses the same value as tap k.
- R3: A sample is taken only on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while reset is asserted and rises at the first edge that samples reset low. Data presented with `in_valid` low, or during reset, has no effect on any later output.
- R4: Each accepted sample gives exactly one `out_valid` pulse of one cycle. The pulse is visible after the fifth clock edge counted from the accepting edge (the accepting edge is the first). No pulse occurs otherwise.
- R5: The full-precision sum is divided by 2^FRAC_W and rounded to the nearest integer, with exact halves moved away from zero (+1.5 → 2, −1.5 → −2).
- R6: Results are clipped to the range −2147483647 to +2147483647. The value −2147483648 is never produced.
- R7: A synchronous active-high reset empties the delay line and the pipeline, drives `out_valid` and `out_data` to zero, and discards results still in flight.
- R8: The sum of two mirrored samples is formed in 33 bits. Two full-scale samples at taps 0 and 99 with c[0] = 3 and FRAC_W = 16 give +196608 and do not wrap.
- R9: The default coefficients have a unity DC gain in Q1.31 (FRAC_W = 31), with a cutoff at 1.5/32 of the sample rate. A sine at 1/64 of the sample rate leaves with a peak within 5 % of its input peak. A sine at 5/32 of the sample rate leaves below 1 % of its input peak.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample is present |
| in_ready | output | 1 | Filter can take a sample this cycle |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Output sample is present (one cycle per accepted input) |
| out_data | output | DATA_W | Signed filtered sample |

## Verification
A shifted or stuck delay-line word appears in the impulse response as a coefficient in the wrong position or a missing one. It shows up within at most 100 outputs, and the out-of-place value is easy to locate. A pre-adder that pairs the wrong taps, or truncates to 32 bits, gives a result far from the expected one when the mirrored pair of full-scale samples reaches the last tap. A bad rounding or clipping stage shows as a one-count error or an unclipped value on the very next output. A broken valid pipeline shows as a pulse one cycle early or late, or a missing pulse, five edges after the accepting edge.

// File: rtl/fir_sym_pkg.sv
package fir_sym_pkg;

   localparam int  DEF_TAPS = 100;
   localparam int  DEF_W    = 32;
   localparam int  DEF_HALF = DEF_TAPS / 2;
   localparam real PI_R     = 3.14159265358979323846;

   // Unnormalised windowed-sinc tap k of a symmetric lowpass; fc is cutoff/sample rate.
   function automatic real raw_tap(input int k, input real fc);
      real m, s, w;
      m = real'(k) - real'(DEF_TAPS - 1) / 2.0;
      s = $sin(2.0 * PI_R * fc * m) / (PI_R * m);
      w = 0.42 - 0.5 * $cos(2.0 * PI_R * real'(k) / real'(DEF_TAPS - 1))
               + 0.08 * $cos(4.0 * PI_R * real'(k) / real'(DEF_TAPS - 1));
      return s * w;
   endfunction

   // Half coefficient set, unity DC gain, quantised with frac fractional bits.
   function automatic logic [DEF_HALF*DEF_W-1:0] lowpass_coefs(input real fc, input int frac);
      logic [DEF_HALF*DEF_W-1:0] packed_c;
      real total, v;
      int  q;
      total = 0.0;
      for (int k = 0; k < DEF_HALF; k++) total += 2.0 * raw_tap(k, fc);
      for (int k = 0; k < DEF_HALF; k++) begin
         v = raw_tap(k, fc) / total * (2.0 ** frac);
         q = $rtoi(v + ((v >= 0.0) ? 0.5 : -0.5));
         packed_c[k*DEF_W +: DEF_W] = q;
      end
      return packed_c;
   endfunction

endpackage

// File: rtl/fir_sym_delay.sv
module fir_sym_delay #(
   parameter int DATA_W = 32,
   parameter int TAPS   = 100
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     shift_en,
   input  logic signed [DATA_W-1:0] din,
   output logic signed [DATA_W-1:0] taps_o [TAPS]
);

   generate
      for (genvar i = 0; i < TAPS; i++) begin : g_stage
         if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (rst)           taps_o[i] <= '0;
               else if (shift_en) taps_o[i] <= din;
            end
         end else begin : g_body
            always_ff @(posedge clk) begin
               if (rst)           taps_o[i] <= '0;
               else if (shift_en) taps_o[i] <= taps_o[i-1];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/fir_sym_preadd.sv
module fir_sym_preadd #(
   parameter int DATA_W = 32,
   parameter int TAPS   = 100,
   localparam int HALF  = TAPS / 2,
   localparam int PW    = DATA_W + 1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     vld_i,
   input  logic signed [DATA_W-1:0] taps_i [TAPS],
   output logic                     vld_o,
   output logic signed [PW-1:0]     pair_o [HALF]
);

   always_ff @(posedge clk) begin
      if (rst) vld_o <= 1'b0;
      else     vld_o <= vld_i;
   end

   generate
      for (genvar k = 0; k < HALF; k++) begin : g_pair
         always_ff @(posedge clk) begin
            if (rst) pair_o[k] <= '0;
            else     pair_o[k] <= PW'(taps_i[k]) + PW'(taps_i[TAPS-1-k]);
         end
      end
   endgenerate

endmodule

// File: rtl/fir_sym_mac.sv
module fir_sym_mac #(
   parameter int PW     = 33,
   parameter int COEF_W = 32,
   parameter int HALF   = 50,
   parameter int AW     = 71,
   parameter logic [HALF*COEF_W-1:0] COEFS = '0,
   localparam int MW    = PW + COEF_W
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 vld_i,
   input  logic signed [PW-1:0] pair_i [HALF],
   output logic                 vld_o,
   output logic signed [AW-1:0] acc_o
);

   logic signed [MW-1:0] prod_q [HALF];
   logic                 prod_vld;
   logic signed [AW-1:0] tree_sum;

   generate
      for (genvar k = 0; k < HALF; k++) begin : g_mul
         localparam logic signed [COEF_W-1:0] CK = COEFS[k*COEF_W +: COEF_W];
         logic signed [MW-1:0] a_x, c_x;
         assign a_x = MW'(pair_i[k]);
         assign c_x = MW'(CK);
         always_ff @(posedge clk) begin
            if (rst) prod_q[k] <= '0;
            else     prod_q[k] <= a_x * c_x;
         end
      end
   endgenerate

   always_comb begin
      tree_sum = '0;
      for (int k = 0; k < HALF; k++) tree_sum = tree_sum + AW'(prod_q[k]);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         prod_vld <= 1'b0;
         vld_o    <= 1'b0;
         acc_o    <= '0;
      end else begin
         prod_vld <= vld_i;
         vld_o    <= prod_vld;
         acc_o    <= tree_sum;
      end
   end

endmodule

// File: rtl/fir_sym_round.sv
module fir_sym_round #(
   parameter int AW     = 71,
   parameter int DATA_W = 32,
   parameter int FRAC_W = 31,
   localparam int XW    = AW + 1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     vld_i,
   input  logic signed [AW-1:0]     acc_i,
   output logic                     vld_o,
   output logic signed [DATA_W-1:0] dout_o
);

   localparam logic signed [XW-1:0] RND_POS = XW'(1) << (FRAC_W - 1);
   localparam logic signed [XW-1:0] RND_NEG = RND_POS - XW'(1);
   localparam logic signed [XW-1:0] POS_LIM = XW'({1'b0, {(DATA_W-1){1'b1}}});
   localparam logic signed [XW-1:0] NEG_LIM = -POS_LIM;

   logic signed [XW-1:0]     biased, scaled;
   logic signed [DATA_W-1:0] clipped;

   always_comb begin
      biased = XW'(acc_i) + (acc_i[AW-1] ? RND_NEG : RND_POS);
      scaled = biased >>> FRAC_W;
      if (scaled > POS_LIM)      clipped = POS_LIM[DATA_W-1:0];
      else if (scaled < NEG_LIM) clipped = NEG_LIM[DATA_W-1:0];
      else                       clipped = scaled[DATA_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_o  <= 1'b0;
         dout_o <= '0;
      end else begin
         vld_o  <= vld_i;
         if (vld_i) dout_o <= clipped;
      end
   end

endmodule

// File: rtl/fir_sym_lowpass.sv
module fir_sym_lowpass #(
   parameter int DATA_W = 32,
   parameter int COEF_W = 32,
   parameter int TAPS   = 100,
   parameter int FRAC_W = 31,
   parameter logic [TAPS/2*COEF_W-1:0] COEFS = fir_sym_pkg::lowpass_coefs(1.5 / 32.0, FRAC_W)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   output logic                     in_ready,
   input  logic signed [DATA_W-1:0] in_data,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_data
);

   localparam int HALF = TAPS / 2;
   localparam int PW   = DATA_W + 1;
   localparam int MW   = PW + COEF_W;
   localparam int AW   = MW + $clog2(HALF);

   generate
      if (TAPS % 2 != 0 || TAPS < 4) begin : g_bad_taps
         $error("TAPS must be even and at least 4");
      end
      if (FRAC_W < 1 || FRAC_W >= AW) begin : g_bad_frac
         $error("FRAC_W out of range");
      end
      if (DATA_W < 2 || DATA_W > 62) begin : g_bad_width
         $error("DATA_W out of range");
      end
   endgenerate

   logic                     rdy_q;
   logic                     take;
   logic                     line_vld;
   logic signed [DATA_W-1:0] line_taps [TAPS];
   logic                     pair_vld;
   logic signed [PW-1:0]     pair_sum [HALF];
   logic                     acc_vld;
   logic signed [AW-1:0]     acc_val;

   always_ff @(posedge clk) rdy_q <= !rst;
   assign in_ready = rdy_q;
   assign take     = in_valid & rdy_q;

   always_ff @(posedge clk) begin
      if (rst) line_vld <= 1'b0;
      else     line_vld <= take;
   end

   fir_sym_delay #(.DATA_W(DATA_W), .TAPS(TAPS)) u_delay (
      .clk(clk), .rst(rst), .shift_en(take), .din(in_data), .taps_o(line_taps));

   fir_sym_preadd #(.DATA_W(DATA_W), .TAPS(TAPS)) u_preadd (
      .clk(clk), .rst(rst), .vld_i(line_vld), .taps_i(line_taps),
      .vld_o(pair_vld), .pair_o(pair_sum));

   fir_sym_mac #(.PW(PW), .COEF_W(COEF_W), .HALF(HALF), .AW(AW), .COEFS(COEFS)) u_mac (
      .clk(clk), .rst(rst), .vld_i(pair_vld), .pair_i(pair_sum),
      .vld_o(acc_vld), .acc_o(acc_val));

   fir_sym_round #(.AW(AW), .DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_round (
      .clk(clk), .rst(rst), .vld_i(acc_vld), .acc_i(acc_val),
      .vld_o(out_valid), .dout_o(out_data));

endmodule

// File: rtl/fir_sym_lowpass_chk.sv
module fir_sym_lowpass_chk #(
   parameter int DATA_W = 32
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     in_valid,
   input logic                     in_ready,
   input logic                     out_valid,
   input logic signed [DATA_W-1:0] out_data
);

   localparam logic signed [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

   // R4: an accepted sample leads to an output pulse five edges later
   a_r4_out_follows_accept: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |-> ##5 out_valid);

   // R4: no output pulse without a matching accepted sample
   a_r4_no_orphan_output: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid && in_ready, 5));

   // R6: the most negative code is never emitted
   a_r6_no_most_negative: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_data != MOST_NEG));

   // R3 and R7: on leaving reset the block is still quiet and not yet ready
   a_r7_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (!out_valid && !in_ready));

   // R4: output pulses last a single cycle unless a back-to-back sample was taken
   a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !$past(in_valid && in_ready, 4)) |=> !out_valid);

endmodule

bind fir_sym_lowpass fir_sym_lowpass_chk #(.DATA_W(DATA_W)) chk_i (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
   .out_valid(out_valid), .out_data(out_data));

// File: tb/fir_sym_lowpass_tb_top.sv
module fir_sym_lowpass_tb_top;

   localparam int DW = 32, CW = 32, TAPS = 100, HALF = 50, FRAC = 16, LAT = 5;
   localparam longint MAXP = 64'sd2147483647;

   function automatic int coef_of(input int k);
      int j;
      j = (k < HALF) ? k : TAPS - 1 - k;
      if (j == 0) return 3;
      return ((j * 7919 + 311) % 150001) - 50000;
   endfunction

   function automatic logic [HALF*CW-1:0] pack_coefs();
      logic [HALF*CW-1:0] r;
      for (int k = 0; k < HALF; k++) r[k*CW +: CW] = coef_of(k);
      return r;
   endfunction

   localparam logic [HALF*CW-1:0] TB_COEFS = pack_coefs();

   // stimulus table: sample value and idle cycles after it
   localparam int NV = 12;
   localparam logic signed [31:0] TV_DATA [NV] = '{32'sd100, -32'sd200, 32'sd2147483647,
      -32'sd2147483648, 32'sd65536, 32'sd0, 32'sd12345, -32'sd1, 32'sd7, -32'sd999999,
      32'sd400000000, -32'sd5};
   localparam int TV_GAP [NV] = '{0, 2, 0, 1, 3, 0, 0, 5, 0, 1, 0, 2};

   logic clk = 1'b0, rst = 1'b1;
   logic in_valid, in_ready, out_valid;
   logic signed [DW-1:0] in_data, out_data;
   logic lp_valid, lp_ready, lp_ovalid;
   logic signed [DW-1:0] lp_data, lp_odata;

   always #5 clk = ~clk;

   fir_sym_lowpass #(.DATA_W(DW), .COEF_W(CW), .TAPS(TAPS), .FRAC_W(FRAC), .COEFS(TB_COEFS)) dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data));

   fir_sym_lowpass dut_lp_i (
      .clk(clk), .rst(rst), .in_valid(lp_valid), .in_ready(lp_ready), .in_data(lp_data),
      .out_valid(lp_ovalid), .out_data(lp_odata));

   typedef struct { longint val; int at; } exp_t;
   exp_t   expq[$];
   longint hist [TAPS];
   int     cyc = 0, n_chk = 0, n_bad = 0, lp_cnt = 0;
   longint last_out = 0, lp_peak = 0;
   string  cur_req = "R7";
   bit     finished = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp_v);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp_v);
      end
   endtask

   task automatic model_accept(input logic signed [31:0] d);
      longint y, q;
      exp_t   e;
      for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = longint'(d);
      y = 0;
      for (int k = 0; k < TAPS; k++) y += hist[k] * longint'(coef_of(k));
      if (y >= 0) q = (y + (64'sd1 << (FRAC - 1))) / (64'sd1 << FRAC);
      else        q = -((-y + (64'sd1 << (FRAC - 1))) / (64'sd1 << FRAC));
      if (q > MAXP)  q = MAXP;
      if (q < -MAXP) q = -MAXP;
      e.val = q;
      e.at  = cyc + LAT;
      expq.push_back(e);
   endtask

   // output monitor for the main instance
   always @(negedge clk) begin
      if (!rst && out_valid) begin
         if (expq.size() == 0) chk(1'b0, "R4 spurious output", longint'(out_data), 0);
         else begin
            exp_t e;
            e = expq.pop_front();
            chk(longint'(out_data) == e.val, cur_req, longint'(out_data), e.val);
            chk(cyc == e.at, "R4 latency", cyc, e.at);
            last_out = longint'(out_data);
         end
      end
   end

   // peak tracker for the default-coefficient instance
   always @(negedge clk) begin
      if (!rst && lp_ovalid) begin
         longint a;
         lp_cnt++;
         a = (lp_odata < 0) ? -longint'(lp_odata) : longint'(lp_odata);
         if (lp_cnt > 200 && a > lp_peak) lp_peak = a;
      end
   end

   task automatic drive(input logic v, input logic signed [31:0] d);
      in_valid = v;
      in_data  = d;
      #1;
      if (v && in_ready) model_accept(d);
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(1'b0, 32'sh0BADF00D);
   endtask

   task automatic apply_reset(input int n);
      rst = 1'b1;
      in_valid = 1'b1;
      in_data  = 32'sh5A5A5A5A;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(in_ready == 1'b0, "R3 ready in reset", in_ready, 0);
         chk(out_valid == 1'b0, "R7 valid in reset", out_valid, 0);
         chk(out_data == '0, "R7 data in reset", longint'(out_data), 0);
      end
      expq.delete();
      for (int k = 0; k < TAPS; k++) hist[k] = 0;
      rst = 1'b0;
      @(negedge clk);
      chk(in_ready == 1'b1, "R3 ready after reset", in_ready, 1);
      in_valid = 1'b0;
   endtask

   task automatic tone(input real f_mhz, output longint peak);
      lp_cnt  = 0;
      lp_peak = 0;
      for (int n = 0; n < 400; n++) begin
         lp_valid = 1'b1;
         lp_data  = $rtoi(1.0e9 * $sin(2.0 * 3.14159265358979 * f_mhz * real'(n) / 32.0));
         @(negedge clk);
      end
      lp_valid = 1'b0;
      repeat (8) @(negedge clk);
      peak = lp_peak;
   endtask

   initial begin : watchdog
      #2000000;
      if (!finished) begin
         chk(1'b0, "R4 watchdog", 0, 1);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      longint pk;
      in_valid = 1'b0; in_data = '0; lp_valid = 1'b0; lp_data = '0;
      for (int k = 0; k < TAPS; k++) hist[k] = 0;

      // R7 reset state, R3 input ignored during reset
      apply_reset(4);

      // R1 R2: impulse gives the coefficient list in order, mirrored half reused
      cur_req = "R1 R2 impulse";
      drive(1'b1, 32'sd65536);
      for (int i = 0; i < TAPS - 1; i++) drive(1'b1, 32'sd0);
      idle(8);
      chk(expq.size() == 0, "R4 all outputs seen", expq.size(), 0);

      // R3 R4: table walk with idle gaps carrying garbage data
      apply_reset(2);
      cur_req = "R3 R4 table";
      for (int i = 0; i < NV; i++) begin
         drive(1'b1, TV_DATA[i]);
         for (int g = 0; g < TV_GAP[i]; g++) drive(1'b0, ~TV_DATA[i]);
      end
      for (int i = 0; i < 5; i++) drive(1'b1, 32'sd0);
      idle(8);
      chk(expq.size() == 0, "R4 one output per sample", expq.size(), 0);

      // R5: exact halves round away from zero
      apply_reset(2);
      cur_req = "R5 rounding";
      drive(1'b1, 32'sd32768);
      idle(7);
      chk(last_out == 2, "R5 +1.5", last_out, 2);
      apply_reset(2);
      drive(1'b1, -32'sd32768);
      idle(7);
      chk(last_out == -2, "R5 -1.5", last_out, -2);
      for (int i = 0; i < 20; i++) drive(1'b1, (i % 2 == 0) ? 32'sd32768 : -32'sd98304);
      idle(8);

      // R6: full-scale steps clip symmetrically
      apply_reset(2);
      cur_req = "R6 saturation";
      for (int i = 0; i < 110; i++) drive(1'b1, 32'sd2147483647);
      idle(8);
      chk(last_out == MAXP, "R6 positive clip", last_out, MAXP);
      for (int i = 0; i < 110; i++) drive(1'b1, -32'sd2147483648);
      idle(8);
      chk(last_out == -MAXP, "R6 negative clip", last_out, -MAXP);

      // R8: mirrored full-scale pair must not wrap in the pre-adder
      apply_reset(2);
      cur_req = "R8 pre-add";
      drive(1'b1, 32'sd2147483647);
      for (int i = 0; i < TAPS - 2; i++) drive(1'b1, 32'sd0);
      drive(1'b1, 32'sd2147483647);
      idle(8);
      chk(last_out == 196608, "R8 pair sum", last_out, 196608);

      // R7: reset during traffic discards in-flight results and history
      apply_reset(2);
      cur_req = "R7 mid-run reset";
      for (int i = 0; i < 10; i++) drive(1'b1, 32'sd1000000);
      apply_reset(2);
      for (int i = 0; i < 8; i++) begin
         chk(out_valid == 1'b0, "R7 flushed", out_valid, 0);
         @(negedge clk);
      end
      drive(1'b1, 32'sd65536);
      for (int i = 0; i < TAPS - 1; i++) drive(1'b1, 32'sd0);
      idle(8);
      chk(expq.size() == 0, "R7 clean restart", expq.size(), 0);

      // R9: default coefficients pass a low tone and stop a high one
      tone(0.5, pk);
      chk(pk > 64'sd950000000 && pk < 64'sd1050000000, "R9 passband", pk, 1000000000);
      tone(5.0, pk);
      chk(pk < 64'sd10000000, "R9 stopband", pk, 10000000);

      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule